// File: doc/BRIEF.md
# Byte-select SRAM bus cycle controller

This block runs single external bus cycles toward a 16-bit asynchronous SRAM whose byte lanes each have their own select input. An internal requester presents an address, a direction, an access size, write data and the index of the address area (0 to 7) the access falls in. Per-area configuration inputs decide how each area is driven. Byte-select mode applies only to an area with a 16-bit bus that is not claimed by a burst ROM or multiplexed address/data protocol. Every other area runs plain strobe cycles.

A cycle has a first state (T1), 0 to 3 wait states and a final state (T2). In byte-select mode the two per-lane write strobe pins carry byte selects during reads and writes alike. The read/write direction line acts as the SRAM write enable. The read strobe is always released in the middle of T2. In plain mode the lane pins are write strobes that open half a cycle into T1. The read strobe release point then comes from a per-area early-release bit. Read data is returned with a one-cycle done pulse.

Top module: `bsram_ctrl`

## Requirements
- R1: During and after reset, and whenever no cycle is in progress, chip select, read strobe, direction line and both lane strobes are high, the data output enable is low and done is low.
- R2: A request accepted at a rising edge makes chip select low for 2 + wait_i cycles (T1, wait_i wait states, T2). done_o is high for exactly the one cycle that follows T2.
- R3: In an area running byte-select mode, the selected lane strobes are low for the whole cycle (T1 to end of T2), in reads as well as writes.
- R4: Lanes are big-endian. A word access selects both lanes and uses the whole of wdata_i. A byte access at an even address selects the upper lane (bits 15:8) and one at an odd address selects the lower lane (bits 7:0). Byte write data is taken from wdata_i[7:0] and driven on both halves of bus_data_o.
- R5: The direction line rw_o is low for the whole of a write cycle and high during reads.
- R6: The read strobe is low from the start of T1. In byte-select mode it rises at the falling edge in the middle of T2, and the area's rdn_early_i bit is ignored. In plain mode it rises at that same falling edge when rdn_early_i of the area is 1, and at the end of T2 when the bit is 0.
- R7: Byte-select mode is in effect only when the area's bs_en_i, wide_i are 1 and its burst_i, mux_i are 0. Otherwise the area runs plain cycles.
- R8: In an area whose wide_i bit is 0, every access is one byte on the upper lane regardless of word_i and address bit 0.
- R9: In plain mode, the lane strobes stay high during reads. During writes the selected lanes go low at the falling edge in the middle of T1 and stay low through the end of T2.
- R10: bus_oe_o is high only during write cycles, from T1 through T2. Read data is captured at the rising edge that ends T2 and held on rdata_o: a word read returns bus_data_i, a byte read returns the selected lane zero-extended.
- R11: A request is taken only when no cycle is in progress. A request held or changed during a cycle is ignored, and addr_o and the cycle's kind stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| addr_i | input | AW | Byte address |
| we_i | input | 1 | 1 = write |
| word_i | input | 1 | 1 = 16-bit access, 0 = byte |
| wdata_i | input | DW | Write data |
| area_i | input | 3 | Area index of the access |
| wait_i | input | 2 | Wait states for this access |
| bs_en_i | input | 8 | Per-area byte-select enable |
| wide_i | input | 8 | Per-area 16-bit bus flag |
| burst_i | input | 8 | Per-area burst ROM flag |
| mux_i | input | 8 | Per-area multiplexed address/data flag |
| rdn_early_i | input | 8 | Per-area plain-mode early read release |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Read data |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| rw_o | output | 1 | Direction line / SRAM write enable (low = write) |
| ubs_n_o | output | 1 | Upper lane strobe, active low |
| lbs_n_o | output | 1 | Lower lane strobe, active low |
| addr_o | output | AW | External address |
| bus_data_i | input | DW | Data bus input |
| bus_data_o | output | DW | Data bus output |
| bus_oe_o | output | 1 | Data bus output enable |

## Verification
Every area is set up differently: plain wide areas with both read release settings, byte-select areas with and without the early bit, and areas whose byte-select bit is defeated by burst, multiplexed or 8-bit settings. This separates the effective-mode decode from the raw enable bit. Word, even-byte and odd-byte accesses in each direction with all four wait counts tell apart lane steering, strobe windows and cycle length. Outputs are checked in both halves of every clock, so early and late strobe edges are distinguished. One request is held and changed while a cycle is running, which shows that requests are taken only when idle.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_T1   = 2'd1,
    ST_TW   = 2'd2,
    ST_T2   = 2'd3
  } bus_st_e;

  typedef struct packed {
    logic we;
    logic word;
    logic bsel;
    logic narrow;
    logic early;
    logic ub;
    logic lb;
  } cyc_attr_t;
endpackage

// File: rtl/bsram_mode_dec.sv
module bsram_mode_dec #(
  parameter int N_AREA = 8,
  localparam int AIW = $clog2(N_AREA)
) (
  input  logic [AIW-1:0]    area_i,
  input  logic [N_AREA-1:0] bs_en_i,
  input  logic [N_AREA-1:0] wide_i,
  input  logic [N_AREA-1:0] burst_i,
  input  logic [N_AREA-1:0] mux_i,
  input  logic [N_AREA-1:0] rdn_early_i,
  output logic              bsel_o,
  output logic              narrow_o,
  output logic              early_o
);
  logic [N_AREA-1:0] bsel_v;
  logic [N_AREA-1:0] early_v;

  // other protocols and 8-bit width take precedence over byte-select
  for (genvar g = 0; g < N_AREA; g++) begin : g_area
    assign bsel_v[g]  = bs_en_i[g] & wide_i[g] & ~burst_i[g] & ~mux_i[g];
    assign early_v[g] = bsel_v[g] | rdn_early_i[g];
  end

  assign bsel_o   = bsel_v[area_i];
  assign narrow_o = ~wide_i[area_i];
  assign early_o  = early_v[area_i];
endmodule

// File: rtl/bsram_lane.sv
module bsram_lane #(
  parameter int DW = 16,
  localparam int LW = DW / 2
) (
  input  logic          word_i,
  input  logic          narrow_i,
  input  logic          a0_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ub_o,
  output logic          lb_o,
  output logic [DW-1:0] wlane_o,
  input  logic          rd_word_i,
  input  logic          rd_ub_i,
  input  logic [DW-1:0] bus_rd_i,
  output logic [DW-1:0] rd_fmt_o
);
  logic full_w;
  assign full_w = word_i & ~narrow_i;

  // big-endian: even byte on upper lane
  assign ub_o    = narrow_i | word_i | ~a0_i;
  assign lb_o    = ~narrow_i & (word_i | a0_i);
  assign wlane_o = full_w ? wdata_i : {wdata_i[LW-1:0], wdata_i[LW-1:0]};

  always_comb begin
    if (rd_word_i)    rd_fmt_o = bus_rd_i;
    else if (rd_ub_i) rd_fmt_o = {{LW{1'b0}}, bus_rd_i[DW-1:LW]};
    else              rd_fmt_o = {{LW{1'b0}}, bus_rd_i[LW-1:0]};
  end
endmodule

// File: rtl/bsram_seq.sv
module bsram_seq import bsram_pkg::*; #(
  parameter int WAIT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WAIT_W-1:0] waits_i,
  output bus_st_e           state_o,
  output logic              last_o
);
  bus_st_e           st_q;
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_T1;
          cnt_q <= waits_i;
        end
        ST_T1: st_q <= (cnt_q == '0) ? ST_T2 : ST_TW;
        ST_TW: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == WAIT_W'(1)) st_q <= ST_T2;
        end
        ST_T2: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = st_q;
  assign last_o  = (st_q == ST_T2);
endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl import bsram_pkg::*; #(
  parameter int AW     = 24,
  parameter int DW     = 16,
  parameter int N_AREA = 8,
  parameter int WAIT_W = 2,
  localparam int AIW   = $clog2(N_AREA)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              we_i,
  input  logic              word_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [AIW-1:0]    area_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic [N_AREA-1:0] bs_en_i,
  input  logic [N_AREA-1:0] wide_i,
  input  logic [N_AREA-1:0] burst_i,
  input  logic [N_AREA-1:0] mux_i,
  input  logic [N_AREA-1:0] rdn_early_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DW-1:0]     rdata_o,
  output logic              cs_n_o,
  output logic              rd_n_o,
  output logic              rw_o,
  output logic              ubs_n_o,
  output logic              lbs_n_o,
  output logic [AW-1:0]     addr_o,
  input  logic [DW-1:0]     bus_data_i,
  output logic [DW-1:0]     bus_data_o,
  output logic              bus_oe_o
);
  logic      dec_bsel, dec_narrow, dec_early;
  logic      ln_ub, ln_lb;
  logic [DW-1:0] ln_wdata, rd_fmt;
  bus_st_e   st;
  logic      last, start, act, in_t1, in_t2;
  cyc_attr_t attr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q, rdata_q;
  logic      done_q;
  logic      t1_late_q, t2_late_q;
  logic      bsel_q;

  bsram_mode_dec #(.N_AREA(N_AREA)) u_mode (
    .area_i      (area_i),
    .bs_en_i     (bs_en_i),
    .wide_i      (wide_i),
    .burst_i     (burst_i),
    .mux_i       (mux_i),
    .rdn_early_i (rdn_early_i),
    .bsel_o      (dec_bsel),
    .narrow_o    (dec_narrow),
    .early_o     (dec_early)
  );

  bsram_lane #(.DW(DW)) u_lane (
    .word_i    (word_i),
    .narrow_i  (dec_narrow),
    .a0_i      (addr_i[0]),
    .wdata_i   (wdata_i),
    .ub_o      (ln_ub),
    .lb_o      (ln_lb),
    .wlane_o   (ln_wdata),
    .rd_word_i (attr_q.ub & attr_q.lb),
    .rd_ub_i   (attr_q.ub),
    .bus_rd_i  (bus_data_i),
    .rd_fmt_o  (rd_fmt)
  );

  bsram_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .waits_i (wait_i),
    .state_o (st),
    .last_o  (last)
  );

  assign act   = (st != ST_IDLE);
  assign in_t1 = (st == ST_T1);
  assign in_t2 = (st == ST_T2);
  assign start = req_i & ~act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      attr_q  <= '0;
      addr_q  <= '0;
      wdat_q  <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last;
      if (start) begin
        attr_q.we     <= we_i;
        attr_q.word   <= word_i;
        attr_q.bsel   <= dec_bsel;
        attr_q.narrow <= dec_narrow;
        attr_q.early  <= dec_early;
        attr_q.ub     <= ln_ub;
        attr_q.lb     <= ln_lb;
        addr_q        <= addr_i;
        wdat_q        <= ln_wdata;
      end
      if (last && !attr_q.we) rdata_q <= rd_fmt;
    end
  end

  // second-half markers, set by the falling edge inside T1 / T2
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t1_late_q <= 1'b0;
      t2_late_q <= 1'b0;
    end else begin
      t1_late_q <= in_t1;
      t2_late_q <= in_t2;
    end
  end

  logic rd_act, wr_open, ub_act, lb_act;
  assign rd_act  = act & ~attr_q.we & ~(attr_q.early & in_t2 & t2_late_q);
  assign wr_open = act & attr_q.we & (~in_t1 | t1_late_q);
  assign ub_act  = attr_q.bsel ? (act & attr_q.ub) : (wr_open & attr_q.ub);
  assign lb_act  = attr_q.bsel ? (act & attr_q.lb) : (wr_open & attr_q.lb);

  assign bsel_q     = attr_q.bsel;
  assign busy_o     = act;
  assign done_o     = done_q;
  assign rdata_o    = rdata_q;
  assign cs_n_o     = ~act;
  assign rd_n_o     = ~rd_act;
  assign rw_o       = ~(act & attr_q.we);
  assign ubs_n_o    = ~ub_act;
  assign lbs_n_o    = ~lb_act;
  assign addr_o     = addr_q;
  assign bus_oe_o   = act & attr_q.we;
  assign bus_data_o = wdat_q;
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
  parameter int AW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          cs_n_o,
  input logic          rd_n_o,
  input logic          rw_o,
  input logic          ubs_n_o,
  input logic          lbs_n_o,
  input logic          bus_oe_o,
  input logic          bsel_q,
  input logic [AW-1:0] addr_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_n_o && rd_n_o && rw_o && ubs_n_o && lbs_n_o && !bus_oe_o));

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_bs_read_lane_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && bsel_q && rw_o) |-> !(ubs_n_o && lbs_n_o));

  p_oe_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (!rw_o && !cs_n_o));

  p_addr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(addr_o));
endmodule

bind bsram_ctrl bsram_chk #(.AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .cs_n_o   (cs_n_o),
  .rd_n_o   (rd_n_o),
  .rw_o     (rw_o),
  .ubs_n_o  (ubs_n_o),
  .lbs_n_o  (lbs_n_o),
  .bus_oe_o (bus_oe_o),
  .bsel_q   (bsel_q),
  .addr_o   (addr_o)
);

// File: tb/sim_bsram_ctrl.sv
module sim_bsram_ctrl;
  localparam int CLK_PERIOD = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [23:0] addr = '0;
  logic        we = 1'b0;
  logic        word = 1'b0;
  logic [15:0] wdata = '0;
  logic [2:0]  area = '0;
  logic [1:0]  wt = '0;
  // area setup: 0 plain, 1/2 byte-select, 3 burst, 4 mux, 5 narrow+bs, 6 plain early, 7 narrow
  logic [7:0]  bs_en = 8'b0011_1110;
  logic [7:0]  wide  = 8'b0101_1111;
  logic [7:0]  burst = 8'b0000_1000;
  logic [7:0]  mux   = 8'b0001_0000;
  logic [7:0]  rdn   = 8'b0100_0100;

  logic        busy, done, cs_n, rd_n, rw, ubs_n, lbs_n, oe;
  logic [15:0] rdata, bdo, bdi;
  logic [23:0] addr_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bdi = {addr_o[7:0] ^ 8'h5A, addr_o[7:0] ^ 8'hC3};

  bsram_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .we_i(we),
    .word_i(word), .wdata_i(wdata), .area_i(area), .wait_i(wt),
    .bs_en_i(bs_en), .wide_i(wide), .burst_i(burst), .mux_i(mux),
    .rdn_early_i(rdn), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .cs_n_o(cs_n), .rd_n_o(rd_n), .rw_o(rw), .ubs_n_o(ubs_n), .lbs_n_o(lbs_n),
    .addr_o(addr_o), .bus_data_i(bdi), .bus_data_o(bdo), .bus_oe_o(oe)
  );

  int checks = 0;
  int errs = 0;
  bit finished = 0;

  // behavioural reference
  bit m_busy = 0, m_done = 0, m_we = 0, m_bsel = 0, m_bsreq = 0, m_narrow = 0;
  bit m_early = 0, m_ub = 0, m_lb = 0, m_word = 0;
  int m_k = 0, m_len = 0;
  logic [23:0] m_addr = '0;
  logic [15:0] m_wd = '0, m_rdata = '0;

  task automatic chk(string tag, logic [31:0] act_v, logic [31:0] exp_v, string what);
    checks++;
    if (act_v !== exp_v) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act_v, exp_v, $time);
    end
  endtask

  task automatic compare(int h);
    bit t1, t2, plain_w, e_rd, e_ub, e_lb;
    string ltag;
    t1 = m_busy && m_k == 0;
    t2 = m_busy && m_k == m_len - 1;
    e_rd = !(m_busy && !m_we && !(m_early && t2 && h == 1));   // R6
    plain_w = m_busy && m_we && !(t1 && h == 0);                // R9
    e_ub = m_bsel ? !(m_busy && m_ub) : !(plain_w && m_ub);
    e_lb = m_bsel ? !(m_busy && m_lb) : !(plain_w && m_lb);
    ltag = m_bsel ? "R3" : (m_bsreq ? "R7" : "R9");
    if (!rst_n) begin
      chk("R1", {cs_n, rd_n, rw, ubs_n, lbs_n, oe, done}, 7'b1111100, "reset outputs");
      return;
    end
    chk("R2", cs_n, !m_busy, "cs_n");
    chk("R2", done, m_done, "done");
    chk("R5", rw, !(m_busy && m_we), "rw");
    chk("R6", rd_n, e_rd, "rd_n");
    chk(ltag, ubs_n, e_ub, "ubs_n");
    chk(ltag, lbs_n, e_lb, "lbs_n");
    chk("R10", oe, m_busy && m_we, "oe");
    chk("R11", busy, m_busy, "busy");
    if (m_busy) chk("R11", addr_o, m_addr, "addr");
    if (m_busy && m_we) chk(m_narrow ? "R8" : "R4", bdo, m_wd, "write data");
    if (m_done && !m_we) chk("R10", rdata, m_rdata, "read data");
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_k = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_k == m_len - 1) begin
          logic [15:0] bus;
          m_busy = 0; m_done = 1;
          bus = {m_addr[7:0] ^ 8'h5A, m_addr[7:0] ^ 8'hC3};
          if (!m_we) m_rdata = (m_ub && m_lb) ? bus : (m_ub ? {8'h00, bus[15:8]} : {8'h00, bus[7:0]});
        end else m_k++;
      end else if (req) begin
        m_busy = 1; m_k = 0; m_len = 2 + int'(wt);
        m_we = we; m_word = word; m_addr = addr;
        m_narrow = !wide[area];                              // R8
        m_bsel = bs_en[area] && wide[area] && !burst[area] && !mux[area];  // R7
        m_bsreq = bs_en[area];
        m_early = m_bsel || rdn[area];
        m_ub = m_narrow || word || !addr[0];                 // R4 big-endian lanes
        m_lb = !m_narrow && (word || addr[0]);
        m_wd = (word && !m_narrow) ? wdata : {wdata[7:0], wdata[7:0]};
      end
    end
    #(CLK_PERIOD/4) compare(0);
    #(CLK_PERIOD/2) compare(1);
  end

  task automatic do_req(input logic [2:0] a_ar, input logic [23:0] a, input logic w,
                        input logic wd_sz, input logic [15:0] d, input logic [1:0] ws,
                        input int hold);
    @(negedge clk);
    while (m_busy) @(negedge clk);
    area = a_ar; addr = a; we = w; word = wd_sz; wdata = d; wt = ws; req = 1'b1;
    @(negedge clk);
    if (hold > 0) begin
      addr = a ^ 24'h0F0F0F; we = ~w; area = 3'd0;   // R11: must be ignored
      repeat (hold) @(negedge clk);
    end
    req = 1'b0;
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    do_req(3'd0, 24'h000100, 1, 1, 16'hA1B2, 2'd0, 0);  // plain word write
    do_req(3'd0, 24'h000102, 0, 1, 16'h0000, 2'd1, 0);  // plain word read, late release
    do_req(3'd0, 24'h000105, 0, 0, 16'h0000, 2'd0, 0);  // plain odd byte read
    do_req(3'd1, 24'h010010, 1, 0, 16'h00C7, 2'd2, 0);  // R3 bs even byte write
    do_req(3'd1, 24'h010011, 0, 0, 16'h0000, 2'd0, 0);  // R3 bs odd byte read
    do_req(3'd1, 24'h010020, 0, 1, 16'h0000, 2'd3, 0);  // bs word read
    do_req(3'd2, 24'h020033, 1, 0, 16'h005E, 2'd1, 0);  // bs with early bit, write
    do_req(3'd2, 24'h020034, 0, 1, 16'h0000, 2'd1, 0);
    do_req(3'd6, 24'h060040, 0, 0, 16'h0000, 2'd2, 0);  // R6 plain early release
    do_req(3'd6, 24'h060042, 1, 1, 16'h1357, 2'd0, 0);
    do_req(3'd3, 24'h030051, 1, 0, 16'h0099, 2'd0, 0);  // R7 burst overrides
    do_req(3'd4, 24'h040060, 0, 0, 16'h0000, 2'd1, 0);  // R7 mux overrides
    do_req(3'd5, 24'h050071, 1, 1, 16'hBEEF, 2'd0, 0);  // R7/R8 narrow overrides
    do_req(3'd7, 24'h070081, 0, 1, 16'h0000, 2'd2, 0);  // R8 narrow read
    do_req(3'd1, 24'h010090, 1, 1, 16'h2468, 2'd3, 2);  // R11 request held while busy
    do_req(3'd0, 24'h0000A7, 1, 0, 16'h00F1, 2'd3, 2);
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule